// File: doc/BRIEF.md
# Expansion Device Select Controller

This block is the bus-side select logic of a plug-in peripheral on an 8-bit expansion bus. It watches the 16-bit address, the read/write line and the phase-2 clock. A single select register is shared by up to eight peripherals. When the CPU writes that register, each device keeps one data bit, chosen by a 3-bit strap, as its own enable flag.

While the flag is set, the device takes over the 2 KB system math ROM range. On CPU reads from that range it pulls the internal math ROM's disable line low, claims the external-select line, and drives chip-select and output-enable of its own ROM. It also decodes a small window just below the select register for its I/O chips. It provides high-active read and write strobes for the select register, which the interrupt logic can use.

The enable flag is a flop clocked by the falling edge of phase 2. The data is stable at the end of the phase-2-high interval, so the flag is captured there. System reset clears the flag asynchronously.

Top module: `expsel_ctrl`

## Requirements
- R1: An active-low `rst_n` clears `dev_enabled` at once, without any phase-2 edge, so the device starts disabled.
- R2: A write (`bus_rw`=0) to address 0xD1FF captures the strapped data bit into the enable flag at the falling edge of `phi2` that ends that cycle.
- R3: Reads of 0xD1FF and writes to any other address leave the enable flag unchanged.
- R4: A strap value of n selects `bus_data[n]`, where bit 0 is the least significant data bit; the other seven bits have no effect.
- R5: While the flag is set, a read (`bus_rw`=1) of 0xD800–0xDFFF with `phi2` high drives `mathrom_off_n` and `ext_claim_n` low.
- R6: Under the condition of R5, `devrom_cs_n` and `devrom_oe_n` are low; in every other case they are high.
- R7: Writes to 0xD800–0xDFFF, reads just outside that range, and any access while the flag is clear leave all four ROM-window outputs high.
- R8: `io_sel_n` is low for any access to 0xD1F0–0xD1FE with `phi2` high while the flag is set; 0xD1FF and 0xD1EF do not select it.
- R9: `selreg_wr` is high during phase-2 high of a write to 0xD1FF, and `selreg_rd` during phase-2 high of a read of it, whatever the flag.
- R10: With `phi2` low, all active-low outputs are high and both strobes are low.
- R11: `dev_enabled` reports the current enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | Phase-2 bus clock; the CPU data phase is high |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_addr | input | 16 | CPU address bus |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_data | input | 8 | CPU data bus (write data) |
| dev_strap | input | 3 | Which data bit belongs to this device |
| dev_enabled | output | 1 | Current enable flag |
| mathrom_off_n | output | 1 | Disables the internal math ROM, active low |
| ext_claim_n | output | 1 | External select claim, active low |
| devrom_cs_n | output | 1 | Device ROM chip select, active low |
| devrom_oe_n | output | 1 | Device ROM output enable, active low |
| io_sel_n | output | 1 | I/O register window select, active low |
| selreg_wr | output | 1 | Select-register write strobe |
| selreg_rd | output | 1 | Select-register read strobe |

## Verification
The bench uses strap values 0, 2 and 7 with data patterns where only the strapped bit differs from the others. A design with a reversed or off-by-one bit pick then enables the device when it should not. It probes the window edges at 0xD7FF, 0xD800, 0xDFFF, 0xE000, 0xD1EF, 0xD1FE and 0xD1FF. A comparator that is one address too wide or too narrow shows up as a wrong select. It also checks that a ROM-range write, a read of the select register and a near-miss write address leave the flag and the ROM outputs alone. A decoder that ignores the read/write line would claim the bus or reload the flag. It drops reset in the middle of phase-2 high to show that clearing does not wait for a clock edge. It also checks every low phase, so an output that is not gated by phase 2 is reported.

// File: rtl/expsel_pkg.sv
package expsel_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SEL_W  = $clog2(DATA_W);

    typedef struct packed {
        logic enabled;
    } sel_state_t;
endpackage

// File: rtl/expsel_window.sv
module expsel_window #(
    parameter int                AW = 16,
    parameter logic [AW-1:0]     LO = '0,
    parameter logic [AW-1:0]     HI = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    // Inclusive range compare; a single address when LO == HI.
    generate
        if (LO == HI) begin : g_exact
            assign hit = (addr == LO);
        end else begin : g_range
            assign hit = (addr >= LO) && (addr <= HI);
        end
    endgenerate
endmodule

// File: rtl/expsel_bitpick.sv
module expsel_bitpick #(
    parameter int DW = 8,
    parameter int SW = $clog2(DW)
) (
    input  logic [DW-1:0] data,
    input  logic [SW-1:0] sel,
    output logic          bit_out
);
    logic [DW-1:0] onehot;
    logic [DW-1:0] masked;

    genvar i;
    generate
        for (i = 0; i < DW; i++) begin : g_lane
            assign onehot[i] = (sel == SW'(i));
            assign masked[i] = onehot[i] & data[i];
        end
    endgenerate

    assign bit_out = |masked;
endmodule

// File: rtl/expsel_ctrl.sv
module expsel_ctrl
    import expsel_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SEL_ADDR  = 16'hD1FF,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hD800,
    parameter int                ROM_LOG2  = 11,
    parameter logic [ADDR_W-1:0] IO_LO     = 16'hD1F0,
    parameter logic [ADDR_W-1:0] IO_HI     = 16'hD1FE
) (
    input  logic              phi2,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rw,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [SEL_W-1:0]  dev_strap,
    output logic              dev_enabled,
    output logic              mathrom_off_n,
    output logic              ext_claim_n,
    output logic              devrom_cs_n,
    output logic              devrom_oe_n,
    output logic              io_sel_n,
    output logic              selreg_wr,
    output logic              selreg_rd
);
    localparam logic [ADDR_W-1:0] ROM_TOP = ROM_BASE + ADDR_W'((1 << ROM_LOG2) - 1);

    logic reg_hit, rom_hit, io_hit, picked;
    sel_state_t st_d, st_q;

    expsel_window #(.AW(ADDR_W), .LO(SEL_ADDR), .HI(SEL_ADDR)) u_reg_win (
        .addr(bus_addr), .hit(reg_hit));
    expsel_window #(.AW(ADDR_W), .LO(ROM_BASE), .HI(ROM_TOP)) u_rom_win (
        .addr(bus_addr), .hit(rom_hit));
    expsel_window #(.AW(ADDR_W), .LO(IO_LO), .HI(IO_HI)) u_io_win (
        .addr(bus_addr), .hit(io_hit));

    expsel_bitpick #(.DW(DATA_W), .SW(SEL_W)) u_pick (
        .data(bus_data), .sel(dev_strap), .bit_out(picked));

    // Next state: the flag is loaded by a select-register write. The
    // phase-2 qualification comes from clocking on the falling edge
    // that ends the high interval.
    always_comb begin
        st_d = st_q;
        if (reg_hit && !bus_rw) begin
            st_d.enabled = picked;
        end
    end

    always_ff @(negedge phi2 or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic rom_take;
    assign rom_take      = phi2 && st_q.enabled && bus_rw && rom_hit;

    assign dev_enabled   = st_q.enabled;
    assign mathrom_off_n = !rom_take;
    assign ext_claim_n   = !rom_take;
    assign devrom_cs_n   = !rom_take;
    assign devrom_oe_n   = !rom_take;
    assign io_sel_n      = !(phi2 && st_q.enabled && io_hit);
    assign selreg_wr     = phi2 && reg_hit && !bus_rw;
    assign selreg_rd     = phi2 && reg_hit && bus_rw;

    // Checks sampled at the end of the data phase (phi2 still high).
    a_r2_capture: assert property (@(negedge phi2) disable iff (!rst_n)
        (bus_addr == SEL_ADDR && !bus_rw) |=> (dev_enabled == $past(bus_data[dev_strap])));

    a_r3_hold: assert property (@(negedge phi2) disable iff (!rst_n)
        !(bus_addr == SEL_ADDR && !bus_rw) |=> $stable(dev_enabled));

    a_r5_claim_cond: assert property (@(negedge phi2) disable iff (!rst_n)
        !mathrom_off_n |-> (dev_enabled && bus_rw && bus_addr[15:11] == 5'b11011));

    a_r6_rom_pair: assert property (@(negedge phi2) disable iff (!rst_n)
        (devrom_cs_n == devrom_oe_n) && (devrom_cs_n == ext_claim_n));

    a_r8_io_enabled: assert property (@(negedge phi2) disable iff (!rst_n)
        !io_sel_n |-> (dev_enabled && bus_addr[15:4] == 12'hD1F));

    // Sampled just before the rising edge, when phi2 is low.
    a_r10_idle: assert property (@(posedge phi2) disable iff (!rst_n)
        (mathrom_off_n && ext_claim_n && devrom_cs_n && devrom_oe_n && io_sel_n
         && !selreg_wr && !selreg_rd));
endmodule

// File: tb/expsel_ctrl_bench.sv
module expsel_ctrl_bench;
    localparam int CLK_PERIOD = 20;

    logic        phi2 = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rw = 1'b1;
    logic [7:0]  bus_data = 8'h00;
    logic [2:0]  dev_strap = 3'd0;
    logic dev_enabled, mathrom_off_n, ext_claim_n, devrom_cs_n, devrom_oe_n;
    logic io_sel_n, selreg_wr, selreg_rd;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) phi2 = ~phi2;

    expsel_ctrl u_expsel_ctrl (
        .phi2(phi2), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rw(bus_rw),
        .bus_data(bus_data), .dev_strap(dev_strap), .dev_enabled(dev_enabled),
        .mathrom_off_n(mathrom_off_n), .ext_claim_n(ext_claim_n),
        .devrom_cs_n(devrom_cs_n), .devrom_oe_n(devrom_oe_n),
        .io_sel_n(io_sel_n), .selreg_wr(selreg_wr), .selreg_rd(selreg_rd));

    typedef struct packed {
        logic [15:0] a;
        logic        rw;
        logic [7:0]  d;
        logic [2:0]  s;
        logic        en;   // flag during this cycle's high phase
        logic        rom;  // ROM window claimed
        logic        io;   // I/O window selected
        logic        wr;
        logic        rd;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{16'hD800, 1'b1, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 disabled
        '{16'hD1F0, 1'b1, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 disabled
        '{16'hD1FF, 1'b0, 8'h04, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 set
        '{16'hD800, 1'b1, 8'h00, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 low edge
        '{16'hDFFF, 1'b1, 8'h00, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 high edge
        '{16'hD7FF, 1'b1, 8'h00, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 below
        '{16'hE000, 1'b1, 8'h00, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 above
        '{16'hD800, 1'b0, 8'h00, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 write
        '{16'hD1F0, 1'b1, 8'h00, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 low
        '{16'hD1FE, 1'b0, 8'h00, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 high, write
        '{16'hD1FF, 1'b1, 8'h00, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R9 read, R3
        '{16'hD1EF, 1'b1, 8'h00, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 below; R3
        '{16'hC1FF, 1'b0, 8'h00, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 near miss
        '{16'hD1FF, 1'b0, 8'hFB, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 clear bit2
        '{16'hD800, 1'b1, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 disabled
        '{16'hD1FF, 1'b0, 8'h80, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 set bit7
        '{16'hDABC, 1'b1, 8'h00, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 mid
        '{16'hD1FF, 1'b0, 8'h7F, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 clear bit7
        '{16'hD1FF, 1'b0, 8'h01, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 set bit0
        '{16'hDC00, 1'b1, 8'h00, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 mid
        '{16'hD1FF, 1'b0, 8'hFE, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 clear bit0
        '{16'hD1F5, 1'b1, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R8 disabled
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] outs();
        return {mathrom_off_n, ext_claim_n, devrom_cs_n, devrom_oe_n, io_sel_n,
                selreg_wr, selreg_rd};
    endfunction

    task automatic check_idle(input string tag);
        check(outs() == 7'b1111100, tag, int'(outs()), 7'b1111100);
    endtask

    task automatic drive(input logic [15:0] a, input logic rw, input logic [7:0] d,
                         input logic [2:0] s);
        bus_addr = a; bus_rw = rw; bus_data = d; dev_strap = s;
    endtask

    initial begin
        #(CLK_PERIOD/4);
        // R1 / R11: reset state
        check(dev_enabled == 1'b0, "R1 reset flag", dev_enabled, 0);
        check_idle("R10 reset outputs");
        #(CLK_PERIOD*2);
        rst_n = 1'b1;
        @(negedge phi2); #(CLK_PERIOD/4);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].a, VEC[i].rw, VEC[i].d, VEC[i].s);
            @(posedge phi2); #(CLK_PERIOD/4);
            check(dev_enabled == VEC[i].en, "R11/R2/R4 flag", dev_enabled, VEC[i].en);
            check(mathrom_off_n == !VEC[i].rom && ext_claim_n == !VEC[i].rom,
                  "R5/R7 claim", {mathrom_off_n, ext_claim_n}, {2{!VEC[i].rom}});
            check(devrom_cs_n == !VEC[i].rom && devrom_oe_n == !VEC[i].rom,
                  "R6 rom select", {devrom_cs_n, devrom_oe_n}, {2{!VEC[i].rom}});
            check(io_sel_n == !VEC[i].io, "R8 io select", io_sel_n, !VEC[i].io);
            check(selreg_wr == VEC[i].wr && selreg_rd == VEC[i].rd, "R9 strobes",
                  {selreg_wr, selreg_rd}, {VEC[i].wr, VEC[i].rd});
            @(negedge phi2); #(CLK_PERIOD/4);
            check_idle("R10 low phase");
        end

        // R10: enabled device, ROM read held across a low phase
        drive(16'hD1FF, 1'b0, 8'h20, 3'd5);
        @(posedge phi2); #(CLK_PERIOD/4);
        @(negedge phi2); #(CLK_PERIOD/4);
        check(dev_enabled == 1'b1, "R2 set bit5", dev_enabled, 1);
        drive(16'hD900, 1'b1, 8'h00, 3'd5);
        #1;
        check_idle("R10 ROM read in low phase");
        @(posedge phi2); #(CLK_PERIOD/4);
        check(devrom_cs_n == 1'b0, "R6 claim after set", devrom_cs_n, 0);

        // R1: asynchronous clear in the middle of phase-2 high
        #1 rst_n = 1'b0;
        #1;
        check(dev_enabled == 1'b0, "R1 async clear", dev_enabled, 0);
        check(devrom_cs_n == 1'b1 && mathrom_off_n == 1'b1, "R1 claim dropped",
              {devrom_cs_n, mathrom_off_n}, 2'b11);
        @(negedge phi2); #(CLK_PERIOD/4);
        rst_n = 1'b1;
        @(posedge phi2); #(CLK_PERIOD/4);
        check(dev_enabled == 1'b0 && devrom_oe_n == 1'b1, "R1 stays off after reset",
              {dev_enabled, devrom_oe_n}, 2'b01);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD*5000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule